// File: doc/BRIEF.md
# Single-Bit Test and Modify Execute Unit

This execute-stage unit handles an instruction group that works on one bit of a 32-bit destination operand. The caller supplies a decoded opcode, the two flag-write enables (carry and zero), an immediate select, the destination value, the source register value, the short immediate field, and the current carry and zero flags. In the same cycle the unit returns the new destination value, a destination write enable, and the next carry and zero flags.

The two flag-write enables choose between two forms of one opcode. When the enables are equal, the instruction writes a computed value into the selected bit. When exactly one enable is set, the destination is left alone. The tested bit, inverted or not, is then folded into the enabled flag by assign, AND, OR or XOR.

A 32-bit LFSR inside the unit supplies the random bit for the random-write opcode. A seed port lets a test bench place the sequence at a known point.

Top module: `bitop_unit`

## Requirements
- R1: The bit index is the low 5 bits of the source operand. The source operand is `s_imm_i` zero-extended when `imm_i`=1, and `s_val_i` when `imm_i`=0. No other source bits affect the index.
- R2: For a group opcode with `wc_i`=0 and `wz_i`=0, the selected bit of the destination is rewritten and `d_we_o`=1. `c_o` equals `c_i` and `z_o` equals `z_i`.
- R3: For a group opcode with `wc_i`=1 and `wz_i`=1, the selected bit is rewritten and `d_we_o`=1. Both `c_o` and `z_o` take the value the selected bit had before it was rewritten.
- R4: For a group opcode with exactly one of `wc_i`/`wz_i` set, `d_we_o`=0 and `d_o` equals `d_val_i`. The flag whose enable is clear passes through unchanged.
- R5: In the test form, the tested value is the selected bit when opcode bit 0 is 0, and its inverse when opcode bit 0 is 1.
- R6: In the test form, opcode bits [2:1] choose how the tested value t meets the old enabled flag f: 00 gives f=t, 01 gives f&t, 10 gives f|t, 11 gives f^t.
- R7: In the modify form, opcode bits [2:0] choose the written bit: 0 writes 0, 1 writes 1, 2 writes C, 3 writes !C, 4 writes Z, 5 writes !Z, 6 writes the random bit, and 7 writes the inverse of the current bit.
- R8: The random bit is LFSR state bit 0. The LFSR steps once per executed modify-form opcode 6, with next state = {q[30:0], q[31]^q[21]^q[1]^q[0]}. Reset sets the state to 1. Raising `seed_load_i` loads `seed_i` at the clock edge, or 1 if `seed_i` is zero. A load takes priority over a step.
- R9: The group is opcodes 0100000 to 0100111. With `valid_i`=1 and any other opcode, `illegal_o`=1, `d_we_o`=0, `d_o` equals `d_val_i`, and both flags pass through.
- R10: With `valid_i`=0, `d_we_o`=0, `illegal_o`=0, `d_o` equals `d_val_i`, both flags pass through, and the LFSR does not step.
- R11: `d_o` differs from `d_val_i` in at most the selected bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock (LFSR only) |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Instruction executes this cycle |
| opcode_i | input | 7 | Decoded major opcode |
| wc_i | input | 1 | Carry write enable |
| wz_i | input | 1 | Zero write enable |
| imm_i | input | 1 | Use immediate as source |
| d_val_i | input | 32 | Destination operand value |
| s_val_i | input | 32 | Source register value |
| s_imm_i | input | 9 | Immediate source field |
| c_i | input | 1 | Current carry flag |
| z_i | input | 1 | Current zero flag |
| seed_load_i | input | 1 | Load LFSR seed at clock edge |
| seed_i | input | 32 | LFSR seed value |
| d_o | output | 32 | Result destination value |
| d_we_o | output | 1 | Destination write enable |
| c_o | output | 1 | Next carry flag |
| z_o | output | 1 | Next zero flag |
| illegal_o | output | 1 | Opcode outside the group |

## Verification
The datapath is combinational, so the assertions assume the operand inputs hold steady through each clock edge at which they are sampled. They also assume `valid_i` frames exactly one instruction per cycle. The bench changes every input only on the falling edge and holds it through the following rising edge. It samples one time unit after driving, so each check sees a settled cycle. The LFSR assertions depend on `seed_load_i` being a single-cycle pulse; the bench drops it on the next falling edge.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
  typedef enum logic [1:0] {CMB_SET, CMB_AND, CMB_OR, CMB_XOR} cmb_e;
  typedef enum logic [2:0] {
    MOD_CLR, MOD_SET, MOD_C, MOD_NC, MOD_Z, MOD_NZ, MOD_RND, MOD_FLIP
  } mod_e;

  typedef struct packed {
    logic legal;
    logic modify;
    logic test;
    logic inv;
    cmb_e cmb;
    mod_e msel;
  } dec_t;

  function automatic logic combine(cmb_e m, logic old, logic t);
    case (m)
      CMB_SET: return t;
      CMB_AND: return old & t;
      CMB_OR:  return old | t;
      default: return old ^ t;
    endcase
  endfunction
endpackage

// File: rtl/bitop_decode.sv
module bitop_decode
  import bitop_pkg::*;
#(
  parameter int unsigned OP_W = 7,
  parameter logic [OP_W-1:0] GROUP_BASE = 7'b0100000
) (
  input  logic [OP_W-1:0] opcode_i,
  input  logic            wc_i,
  input  logic            wz_i,
  output dec_t            dec_o
);
  localparam int unsigned SUB_W = 3;

  logic legal;
  assign legal = (opcode_i[OP_W-1:SUB_W] == GROUP_BASE[OP_W-1:SUB_W]);

  always_comb begin
    dec_o.legal  = legal;
    dec_o.modify = legal & (wc_i == wz_i);
    dec_o.test   = legal & (wc_i ^ wz_i);
    dec_o.inv    = opcode_i[0];
    dec_o.cmb    = cmb_e'(opcode_i[2:1]);
    dec_o.msel   = mod_e'(opcode_i[SUB_W-1:0]);
  end
endmodule

// File: rtl/bitop_lfsr.sv
module bitop_lfsr #(
  parameter int unsigned   W          = 32,
  parameter logic [W-1:0]  TAPS       = 32'h8020_0003,
  parameter logic [W-1:0]  RESET_SEED = 32'h0000_0001
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         adv_i,
  input  logic         load_i,
  input  logic [W-1:0] seed_i,
  output logic         rnd_o
);
  logic [W-1:0] state_q;
  logic         fb;

  assign fb    = ^(state_q & TAPS);
  assign rnd_o = state_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= RESET_SEED;
    else if (load_i) state_q <= (seed_i == '0) ? RESET_SEED : seed_i;
    else if (adv_i)  state_q <= {state_q[W-2:0], fb};
  end

  p_lfsr_nonzero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0);
  p_lfsr_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !load_i) |=> $stable(state_q));
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bitop_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IMM_W  = 9,
  parameter int unsigned OP_W   = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [OP_W-1:0]   opcode_i,
  input  logic              wc_i,
  input  logic              wz_i,
  input  logic              imm_i,
  input  logic [DATA_W-1:0] d_val_i,
  input  logic [DATA_W-1:0] s_val_i,
  input  logic [IMM_W-1:0]  s_imm_i,
  input  logic              c_i,
  input  logic              z_i,
  input  logic              seed_load_i,
  input  logic [DATA_W-1:0] seed_i,
  output logic [DATA_W-1:0] d_o,
  output logic              d_we_o,
  output logic              c_o,
  output logic              z_o,
  output logic              illegal_o
);
  localparam int unsigned IDX_W = $clog2(DATA_W);

  dec_t             dec;
  logic [IDX_W-1:0] idx;
  logic             cur_bit, tbit, new_bit, rnd, lfsr_adv;

  bitop_decode #(.OP_W(OP_W)) i_decode (
    .opcode_i(opcode_i), .wc_i(wc_i), .wz_i(wz_i), .dec_o(dec)
  );

  assign lfsr_adv = valid_i & dec.modify & (dec.msel == MOD_RND);

  bitop_lfsr #(.W(DATA_W)) i_lfsr (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(lfsr_adv),
    .load_i(seed_load_i), .seed_i(seed_i), .rnd_o(rnd)
  );

  assign idx     = imm_i ? s_imm_i[IDX_W-1:0] : s_val_i[IDX_W-1:0];
  assign cur_bit = d_val_i[idx];
  assign tbit    = cur_bit ^ dec.inv;

  always_comb begin
    case (dec.msel)
      MOD_CLR: new_bit = 1'b0;
      MOD_SET: new_bit = 1'b1;
      MOD_C:   new_bit = c_i;
      MOD_NC:  new_bit = ~c_i;
      MOD_Z:   new_bit = z_i;
      MOD_NZ:  new_bit = ~z_i;
      MOD_RND: new_bit = rnd;
      default: new_bit = ~cur_bit;
    endcase
  end

  always_comb begin
    d_o       = d_val_i;
    d_we_o    = 1'b0;
    c_o       = c_i;
    z_o       = z_i;
    illegal_o = 1'b0;
    if (valid_i) begin
      if (!dec.legal) begin
        illegal_o = 1'b1;
      end else if (dec.modify) begin
        d_o[idx] = new_bit;
        d_we_o   = 1'b1;
        if (wc_i) begin
          c_o = cur_bit;
          z_o = cur_bit;
        end
      end else begin
        if (wc_i) c_o = combine(dec.cmb, c_i, tbit);
        if (wz_i) z_o = combine(dec.cmb, z_i, tbit);
      end
    end
  end

  p_illegal_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && illegal_o) |-> (!d_we_o && d_o == d_val_i && c_o == c_i && z_o == z_i));
  p_test_no_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !illegal_o && (wc_i != wz_i)) |-> (!d_we_o && d_o == d_val_i));
  p_plain_modify_flags_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !illegal_o && !wc_i && !wz_i) |-> (d_we_o && c_o == c_i && z_o == z_i));
  p_both_flags_equal_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !illegal_o && wc_i && wz_i) |-> (d_we_o && c_o == z_o));
  p_single_bit_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(d_o ^ d_val_i) <= 1);
  p_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> (!d_we_o && !illegal_o && c_o == c_i && z_o == z_i));
endmodule

// File: tb/test_bitop_unit.sv
`timescale 1ns/1ps
module test_bitop_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [6:0]  op = '0;
  logic        wc = 1'b0, wz = 1'b0, imm = 1'b0, c = 1'b0, z = 1'b0;
  logic [31:0] dv = '0, sv = '0, seed = '0;
  logic [8:0]  simm = '0;
  logic        sload = 1'b0;
  logic [31:0] d_o;
  logic        d_we, c_o, z_o, ill;

  int checks = 0;
  int fails  = 0;
  logic [31:0] lfsr_m = 32'h1;

  always #2.5 clk = ~clk;

  bitop_unit i_bitop_unit (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .opcode_i(op),
    .wc_i(wc), .wz_i(wz), .imm_i(imm), .d_val_i(dv), .s_val_i(sv),
    .s_imm_i(simm), .c_i(c), .z_i(z), .seed_load_i(sload), .seed_i(seed),
    .d_o(d_o), .d_we_o(d_we), .c_o(c_o), .z_o(z_o), .illegal_o(ill)
  );

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  function automatic logic [31:0] lfsr_next(logic [31:0] q);
    return {q[30:0], q[31] ^ q[21] ^ q[1] ^ q[0]};
  endfunction

  task automatic run(input logic v, input logic [6:0] o, input logic fc, input logic fz,
                     input logic im, input logic [31:0] d, input logic [31:0] s,
                     input logic [8:0] si, input logic ci, input logic zi, input string tag);
    logic [4:0]  ix;
    logic        b, t, nb, ec, ez, ew, ei;
    logic [31:0] ed;
    @(negedge clk);
    valid = v; op = o; wc = fc; wz = fz; imm = im; dv = d; sv = s; simm = si; c = ci; z = zi;
    #1;
    ix = im ? si[4:0] : s[4:0];
    b  = d[ix];
    ed = d; ew = 1'b0; ec = ci; ez = zi; ei = 1'b0;
    if (v) begin
      if (o[6:3] != 4'b0100) ei = 1'b1;
      else if (fc == fz) begin
        case (o[2:0])
          3'd0: nb = 1'b0;
          3'd1: nb = 1'b1;
          3'd2: nb = ci;
          3'd3: nb = ~ci;
          3'd4: nb = zi;
          3'd5: nb = ~zi;
          3'd6: nb = lfsr_m[0];
          default: nb = ~b;
        endcase
        ed[ix] = nb; ew = 1'b1;
        if (fc) begin ec = b; ez = b; end
      end else begin
        t = b ^ o[0];
        if (fc) case (o[2:1])
          2'd0: ec = t; 2'd1: ec = ci & t; 2'd2: ec = ci | t; default: ec = ci ^ t;
        endcase
        if (fz) case (o[2:1])
          2'd0: ez = t; 2'd1: ez = zi & t; 2'd2: ez = zi | t; default: ez = zi ^ t;
        endcase
      end
    end
    checks++;
    if (d_o !== ed || d_we !== ew || c_o !== ec || z_o !== ez || ill !== ei) begin
      fails++;
      $display("FAIL %s op=%b wc=%b wz=%b: got d=%h we=%b c=%b z=%b ill=%b exp d=%h we=%b c=%b z=%b ill=%b",
               tag, o, fc, fz, d_o, d_we, c_o, z_o, ill, ed, ew, ec, ez, ei);
    end
    if (v && o[6:3] == 4'b0100 && fc == fz && o[2:0] == 3'd6) lfsr_m = lfsr_next(lfsr_m);
  endtask

  task automatic load_seed(input logic [31:0] sd);
    @(negedge clk);
    valid = 1'b0; sload = 1'b1; seed = sd;
    @(negedge clk);
    sload = 1'b0;
    lfsr_m = (sd == 32'h0) ? 32'h1 : sd;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R8: reset state is 1, so the first random write produces 1
    run(1, 7'b0100110, 0, 0, 0, 32'h0, 32'h0, 9'h0, 0, 0, "R8");

    // Sweep: all sub-opcodes x flag-enable pairs x flags x bit value (R2 R3 R4 R5 R6 R7)
    for (int sub = 0; sub < 8; sub++)
      for (int f = 0; f < 4; f++)
        for (int cz = 0; cz < 4; cz++)
          for (int bv = 0; bv < 2; bv++) begin
            logic [4:0]  ix;
            logic [31:0] d;
            string       tg;
            ix = 5'((sub * 5 + f * 3 + cz * 7 + bv) % 32);
            d  = 32'hA5C3_0F96 ^ (32'h1 << ((ix + 9) % 32));
            d[ix] = bv[0];
            tg = (f == 0) ? "R2_R7" : (f == 3) ? "R3_R7" : (sub[0] ? "R5_R6" : "R4_R6");
            run(1, 7'(7'b0100000 + sub), f[1], f[0], bv[0], d, {27'h5AA5A5A, ~ix},
                {4'hF, ix}, cz[1], cz[0], tg);
          end

    // R1: upper immediate bits and non-selected register bits are ignored
    run(1, 7'b0100001, 0, 0, 1, 32'h0000_0000, 32'hFFFF_FFFF, 9'h1E3, 0, 0, "R1");
    run(1, 7'b0100001, 0, 0, 0, 32'h0000_0000, 32'hFFFF_FFE7, 9'h1FF, 0, 0, "R1");
    run(1, 7'b0100000, 1, 0, 1, 32'h8000_0000, 32'h0, 9'h0FF, 0, 0, "R1");

    // R5 explicit: odd opcode tests inverse
    run(1, 7'b0100001, 0, 1, 0, 32'h0000_0010, 32'h4, 9'h0, 0, 0, "R5");
    run(1, 7'b0100001, 0, 1, 0, 32'h0000_0010, 32'h4, 9'h0, 0, 1, "R5");

    // R11: modify all-ones / all-zeros at edge indices
    run(1, 7'b0100111, 0, 0, 0, 32'hFFFF_FFFF, 32'd31, 9'h0, 0, 0, "R11");
    run(1, 7'b0100111, 1, 1, 0, 32'h0000_0000, 32'd0, 9'h0, 0, 0, "R11");

    // R9: every opcode outside the group
    for (int o = 0; o < 128; o++)
      if (o[6:3] != 4'b0100)
        run(1, 7'(o), o[0], o[1], o[2], 32'h1234_5678 ^ o, 32'(o), 9'(o), o[3], o[4], "R9");

    // R10: idle cycles, including a random opcode that must not step the LFSR
    run(0, 7'b0100110, 0, 0, 0, 32'h0F0F_0F0F, 32'd3, 9'h0, 1, 0, "R10");
    run(0, 7'b0100110, 1, 1, 1, 32'hF0F0_F0F0, 32'd0, 9'h5, 0, 1, "R10");
    for (int k = 0; k < 4; k++)
      run(1, 7'b0100110, 0, 0, 0, 32'h0, 32'd0, 9'h0, 0, 0, "R10_R8");

    // R8: seeded sequence, plus zero seed mapping to 1
    load_seed(32'hDEAD_BEEF);
    for (int k = 0; k < 40; k++)
      run(1, 7'b0100110, k[0], k[0], 0, 32'h0, 32'(k), 9'h0, 0, 0, "R8");
    load_seed(32'h0);
    for (int k = 0; k < 8; k++)
      run(1, 7'b0100110, 0, 0, 1, 32'hFFFF_FFFF, 32'h0, 9'(k), 0, 0, "R8");

    @(negedge clk);
    valid = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule